// File: doc/BRIEF.md
# CAM Priority-Chain Flag Controller

This block is the per-device flag logic that lets several identical content-addressable memory devices be chained by priority with no external gates. Each copy takes the local compare outcome (hit, more than one hit), the local full condition, a synchronous active-low chip enable and the operation code. It combines these with flags from its neighbours, which arrive from two directions. Match information runs toward lower-priority devices on the down path and toward higher-priority devices on the up path. The full indication runs only down the chain.

The device that owns a compare result is the highest-priority device holding a hit. The device granted a next-free-address write is the highest-priority device that still has room. A deselected device either passes its neighbour flags straight through (chain build) or drives fixed idle levels (single-device build). A device that has just been reset or re-enabled ignores every operation until it sees a no-operation cycle with chip enable active.

Top module: `cfl_cascade_ctrl`

## Requirements
- R1: While reset is high, and in the wake state that follows reset until a no-operation is accepted, the device drives mfu_out_n, mfd_out_n, mmf_out_n, smf_out_n and ff_out_n high, and drives cscu_out, cscd_out, owns_o and nfa_wr_o low.
- R2: The device becomes active only at a clock edge where ce_n is low and op_i is NOP (00). Before that edge it ignores every other code, including compare (01) and fill (10).
- R3: In an active device a compare (01) registers loc_match_i. mfd_out_n is low while the registered hit is set or mfd_in_n is low. mfu_out_n is low while the registered hit is set or mfu_in_n is low. smf_out_n always equals mfd_out_n.
- R4: owns_o is high only when the device is active, its registered hit is set and mfd_in_n is high. In a chain, exactly the highest-priority device with a hit owns the result.
- R5: mmf_out_n is low when any of these holds: the registered local multiple-hit is set, mmf_in_n is low, or the registered hit is set while mfd_in_n is low.
- R6: A fill (10) registers loc_full_i as the local full state. ff_out_n is low when the local full state is set and ff_in_n is low. nfa_wr_o is high when ff_in_n is low and the local full state is clear.
- R7: In a chain build (CASCADED=1), a device whose ce_n was high at the last edge passes mfu_in_n, mfd_in_n, mmf_in_n, ff_in_n, cscu_in and cscd_in to the matching outputs. smf_out_n follows mfd_in_n. owns_o and nfa_wr_o are low.
- R8: In a single-device build (CASCADED=0), a deselected device drives mfu_out_n, mfd_out_n, mmf_out_n and smf_out_n high, ff_out_n low, and cscu_out, cscd_out, owns_o and nfa_wr_o low.
- R9: cscd_out equals cscd_in OR a participation bit, and cscu_out equals cscu_in OR the same bit. The participation bit is set for one cycle after an active device executes any code other than NOP.
- R10: The registered hit and multiple-hit change only on a compare in an active device, and both are cleared when the device is deselected or waking. The local full state changes only on a fill in an active device and is kept across deselection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low, sampled at the clock edge |
| op_i | input | 2 | Operation: 00 NOP, 01 compare, 10 fill (full-updating write), 11 other |
| loc_match_i | input | 1 | Local array reports at least one hit |
| loc_multi_i | input | 1 | Local array reports more than one hit |
| loc_full_i | input | 1 | Local array has no free entry |
| mfu_in_n | input | 1 | Match-up from the next lower-priority device |
| mfd_in_n | input | 1 | Match-down from the next higher-priority device |
| mmf_in_n | input | 1 | Multiple-match from the next higher-priority device |
| ff_in_n | input | 1 | Full from the next higher-priority device |
| cscu_in | input | 1 | Participation strobe from below |
| cscd_in | input | 1 | Participation strobe from above |
| mfu_out_n | output | 1 | Match-up toward higher priority |
| mfd_out_n | output | 1 | Match-down toward lower priority |
| mmf_out_n | output | 1 | Multiple-match toward lower priority |
| ff_out_n | output | 1 | Full toward lower priority |
| smf_out_n | output | 1 | System match, same as match-down |
| cscu_out | output | 1 | Participation strobe toward higher priority |
| cscd_out | output | 1 | Participation strobe toward lower priority |
| owns_o | output | 1 | This device owns the current compare result |
| nfa_wr_o | output | 1 | This device takes a next-free-address write |

## Verification
The bench builds three copies with CASCADED=1, wired as a highest, middle and lowest priority chain, and one copy with CASCADED=0 tied as a lone device. The chain brings ownership arbitration, multiple-match formed across devices, full propagation and two-way pass-through of a deselected middle device within reach. The lone copy covers the fixed idle levels. Random enables, operations and occasional resets drive every device through deselect, wake and active states, including re-enable with and without an immediate no-operation.

// File: rtl/cfl_pkg.sv
`timescale 1ns/1ps
package cfl_pkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 2'b00,
    OP_CMP  = 2'b01,
    OP_FILL = 2'b10,
    OP_MISC = 2'b11
  } cfl_op_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_WAKE = 2'b01,
    ST_ON   = 2'b10
  } cfl_st_e;

  typedef struct packed {
    logic hit;
    logic multi;
    logic full;
    logic part;
  } cfl_local_t;
endpackage

// File: rtl/cfl_enable_seq.sv
`timescale 1ns/1ps
module cfl_enable_seq
  import cfl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ce_n,
  input  cfl_op_e op,
  output cfl_st_e state_q,
  output logic    exec
);
  cfl_st_e state_d;

  always_comb begin
    state_d = state_q;
    if (ce_n) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_ON:   state_d = ST_ON;
        default: state_d = (op == OP_NOP) ? ST_ON : ST_WAKE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_WAKE;
    else     state_q <= state_d;
  end

  // An operation is carried out only by an active, selected device
  assign exec = (state_q == ST_ON) && !ce_n;

  AST_WAKE_NEEDS_NOP: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_ON && !ce_n && op != OP_NOP) |=> (state_q != ST_ON)); // R2

  AST_DESELECT_GOES_OFF: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (state_q == ST_OFF)); // R7
endmodule

// File: rtl/cfl_status_regs.sv
`timescale 1ns/1ps
module cfl_status_regs
  import cfl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       exec,
  input  cfl_op_e    op,
  input  logic       loc_match,
  input  logic       loc_multi,
  input  logic       loc_full,
  output cfl_local_t lq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lq <= '0;
    end else if (!exec) begin
      lq.hit   <= 1'b0;
      lq.multi <= 1'b0;
      lq.part  <= 1'b0;
    end else begin
      lq.part <= (op != OP_NOP);
      if (op == OP_CMP) begin
        lq.hit   <= loc_match;
        lq.multi <= loc_multi;
      end
      if (op == OP_FILL) lq.full <= loc_full;
    end
  end

  AST_FULL_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    !(exec && op == OP_FILL) |=> $stable(lq.full)); // R10

  AST_HIT_ONLY_ON_CMP: assert property (@(posedge clk) disable iff (rst)
    (exec && op != OP_CMP) |=> ($stable(lq.hit) && $stable(lq.multi))); // R10
endmodule

// File: rtl/cfl_chain_merge.sv
`timescale 1ns/1ps
module cfl_chain_merge
  import cfl_pkg::*;
#(
  parameter bit CASCADED = 1'b1
) (
  input  cfl_st_e    st,
  input  cfl_local_t lq,
  input  logic       mfu_in_n,
  input  logic       mfd_in_n,
  input  logic       mmf_in_n,
  input  logic       ff_in_n,
  input  logic       cscu_in,
  input  logic       cscd_in,
  output logic       mfu_out_n,
  output logic       mfd_out_n,
  output logic       mmf_out_n,
  output logic       ff_out_n,
  output logic       cscu_out,
  output logic       cscd_out,
  output logic       owns,
  output logic       nfa_wr
);
  logic off_mfu, off_mfd, off_mmf, off_ff, off_cscu, off_cscd;

  generate
    if (CASCADED) begin : g_pass
      assign off_mfu  = mfu_in_n;
      assign off_mfd  = mfd_in_n;
      assign off_mmf  = mmf_in_n;
      assign off_ff   = ff_in_n;
      assign off_cscu = cscu_in;
      assign off_cscd = cscd_in;
    end else begin : g_tie
      assign off_mfu  = 1'b1;
      assign off_mfd  = 1'b1;
      assign off_mmf  = 1'b1;
      assign off_ff   = 1'b0;
      assign off_cscu = 1'b0;
      assign off_cscd = 1'b0;
    end
  endgenerate

  always_comb begin
    mfu_out_n = 1'b1;
    mfd_out_n = 1'b1;
    mmf_out_n = 1'b1;
    ff_out_n  = 1'b1;
    cscu_out  = 1'b0;
    cscd_out  = 1'b0;
    owns      = 1'b0;
    nfa_wr    = 1'b0;
    case (st)
      ST_ON: begin
        mfd_out_n = !(lq.hit || !mfd_in_n);
        mfu_out_n = !(lq.hit || !mfu_in_n);
        mmf_out_n = !(lq.multi || !mmf_in_n || (lq.hit && !mfd_in_n));
        ff_out_n  = !(lq.full && !ff_in_n);
        cscu_out  = lq.part || cscu_in;
        cscd_out  = lq.part || cscd_in;
        owns      = lq.hit && mfd_in_n;
        nfa_wr    = !ff_in_n && !lq.full;
      end
      ST_OFF: begin
        mfu_out_n = off_mfu;
        mfd_out_n = off_mfd;
        mmf_out_n = off_mmf;
        ff_out_n  = off_ff;
        cscu_out  = off_cscu;
        cscd_out  = off_cscd;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cfl_cascade_ctrl.sv
`timescale 1ns/1ps
module cfl_cascade_ctrl
  import cfl_pkg::*;
#(
  parameter bit CASCADED = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic [1:0] op_i,
  input  logic       loc_match_i,
  input  logic       loc_multi_i,
  input  logic       loc_full_i,
  input  logic       mfu_in_n,
  input  logic       mfd_in_n,
  input  logic       mmf_in_n,
  input  logic       ff_in_n,
  input  logic       cscu_in,
  input  logic       cscd_in,
  output logic       mfu_out_n,
  output logic       mfd_out_n,
  output logic       mmf_out_n,
  output logic       ff_out_n,
  output logic       smf_out_n,
  output logic       cscu_out,
  output logic       cscd_out,
  output logic       owns_o,
  output logic       nfa_wr_o
);
  cfl_op_e    op;
  cfl_st_e    st;
  logic       exec;
  cfl_local_t lq;

  assign op = cfl_op_e'(op_i);

  cfl_enable_seq u_seq (
    .clk(clk), .rst(rst), .ce_n(ce_n), .op(op),
    .state_q(st), .exec(exec)
  );

  cfl_status_regs u_regs (
    .clk(clk), .rst(rst), .exec(exec), .op(op),
    .loc_match(loc_match_i), .loc_multi(loc_multi_i), .loc_full(loc_full_i),
    .lq(lq)
  );

  cfl_chain_merge #(.CASCADED(CASCADED)) u_merge (
    .st(st), .lq(lq),
    .mfu_in_n(mfu_in_n), .mfd_in_n(mfd_in_n), .mmf_in_n(mmf_in_n),
    .ff_in_n(ff_in_n), .cscu_in(cscu_in), .cscd_in(cscd_in),
    .mfu_out_n(mfu_out_n), .mfd_out_n(mfd_out_n), .mmf_out_n(mmf_out_n),
    .ff_out_n(ff_out_n), .cscu_out(cscu_out), .cscd_out(cscd_out),
    .owns(owns_o), .nfa_wr(nfa_wr_o)
  );

  assign smf_out_n = mfd_out_n;

  AST_OWNER_PULLS_DOWN: assert property (@(posedge clk) disable iff (rst)
    owns_o |-> (!mfd_out_n && !mfu_out_n)); // R4

  AST_GRANT_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    nfa_wr_o |-> ff_out_n); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (mfd_out_n && mfu_out_n && mmf_out_n && ff_out_n && !owns_o && !cscd_out)); // R1
endmodule

// File: tb/tb_cfl_cascade_ctrl.sv
`timescale 1ns/1ps
module tb_cfl_cascade_ctrl;
  localparam int ND = 4;   // 0..2 chain (0 highest), 3 lone device
  localparam int S_OFF = 0, S_WAKE = 1, S_ON = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       ce_n [ND];
  logic [1:0] op   [ND];
  logic       lm [ND], lmm [ND], lf [ND];

  logic w_mfu [ND], w_mfd [ND], w_mmf [ND], w_ff [ND], w_smf [ND];
  logic w_cu [ND], w_cd [ND], w_own [ND], w_nfa [ND];

  cfl_cascade_ctrl #(.CASCADED(1'b1)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n[0]), .op_i(op[0]),
    .loc_match_i(lm[0]), .loc_multi_i(lmm[0]), .loc_full_i(lf[0]),
    .mfu_in_n(w_mfu[1]), .mfd_in_n(1'b1), .mmf_in_n(1'b1), .ff_in_n(1'b0),
    .cscu_in(w_cu[1]), .cscd_in(1'b0),
    .mfu_out_n(w_mfu[0]), .mfd_out_n(w_mfd[0]), .mmf_out_n(w_mmf[0]),
    .ff_out_n(w_ff[0]), .smf_out_n(w_smf[0]), .cscu_out(w_cu[0]),
    .cscd_out(w_cd[0]), .owns_o(w_own[0]), .nfa_wr_o(w_nfa[0]));

  cfl_cascade_ctrl #(.CASCADED(1'b1)) u_dev1 (
    .clk(clk), .rst(rst), .ce_n(ce_n[1]), .op_i(op[1]),
    .loc_match_i(lm[1]), .loc_multi_i(lmm[1]), .loc_full_i(lf[1]),
    .mfu_in_n(w_mfu[2]), .mfd_in_n(w_mfd[0]), .mmf_in_n(w_mmf[0]), .ff_in_n(w_ff[0]),
    .cscu_in(w_cu[2]), .cscd_in(w_cd[0]),
    .mfu_out_n(w_mfu[1]), .mfd_out_n(w_mfd[1]), .mmf_out_n(w_mmf[1]),
    .ff_out_n(w_ff[1]), .smf_out_n(w_smf[1]), .cscu_out(w_cu[1]),
    .cscd_out(w_cd[1]), .owns_o(w_own[1]), .nfa_wr_o(w_nfa[1]));

  cfl_cascade_ctrl #(.CASCADED(1'b1)) u_dev2 (
    .clk(clk), .rst(rst), .ce_n(ce_n[2]), .op_i(op[2]),
    .loc_match_i(lm[2]), .loc_multi_i(lmm[2]), .loc_full_i(lf[2]),
    .mfu_in_n(1'b1), .mfd_in_n(w_mfd[1]), .mmf_in_n(w_mmf[1]), .ff_in_n(w_ff[1]),
    .cscu_in(1'b0), .cscd_in(w_cd[1]),
    .mfu_out_n(w_mfu[2]), .mfd_out_n(w_mfd[2]), .mmf_out_n(w_mmf[2]),
    .ff_out_n(w_ff[2]), .smf_out_n(w_smf[2]), .cscu_out(w_cu[2]),
    .cscd_out(w_cd[2]), .owns_o(w_own[2]), .nfa_wr_o(w_nfa[2]));

  cfl_cascade_ctrl #(.CASCADED(1'b0)) u_single (
    .clk(clk), .rst(rst), .ce_n(ce_n[3]), .op_i(op[3]),
    .loc_match_i(lm[3]), .loc_multi_i(lmm[3]), .loc_full_i(lf[3]),
    .mfu_in_n(1'b1), .mfd_in_n(1'b1), .mmf_in_n(1'b1), .ff_in_n(1'b0),
    .cscu_in(1'b0), .cscd_in(1'b0),
    .mfu_out_n(w_mfu[3]), .mfd_out_n(w_mfd[3]), .mmf_out_n(w_mmf[3]),
    .ff_out_n(w_ff[3]), .smf_out_n(w_smf[3]), .cscu_out(w_cu[3]),
    .cscd_out(w_cd[3]), .owns_o(w_own[3]), .nfa_wr_o(w_nfa[3]));

  // ---------------- behavioural reference ----------------
  int   m_st [ND];
  logic m_hit [ND], m_mul [ND], m_full [ND], m_part [ND];
  logic e_mfu [ND], e_mfd [ND], e_mmf [ND], e_ff [ND];
  logic e_cu [ND], e_cd [ND], e_own [ND], e_nfa [ND];

  always @(posedge clk) begin
    for (int d = 0; d < ND; d++) begin
      if (rst) begin
        m_st[d] = S_WAKE; m_hit[d] = 0; m_mul[d] = 0; m_full[d] = 0; m_part[d] = 0;
      end else if (ce_n[d]) begin
        m_st[d] = S_OFF; m_hit[d] = 0; m_mul[d] = 0; m_part[d] = 0;
      end else if (m_st[d] == S_ON) begin
        m_part[d] = (op[d] != 2'd0);
        if (op[d] == 2'd1) begin m_hit[d] = lm[d]; m_mul[d] = lmm[d]; end
        if (op[d] == 2'd2) m_full[d] = lf[d];
      end else begin
        m_st[d] = (op[d] == 2'd0) ? S_ON : S_WAKE;
        m_hit[d] = 0; m_mul[d] = 0; m_part[d] = 0;
      end
    end
  end

  function automatic void dev_out(int d, bit casc, logic ui, logic di, logic mi,
                                  logic fi, logic cui, logic cdi);
    e_mfu[d] = 1; e_mfd[d] = 1; e_mmf[d] = 1; e_ff[d] = 1;
    e_cu[d] = 0; e_cd[d] = 0; e_own[d] = 0; e_nfa[d] = 0;
    if (m_st[d] == S_ON) begin
      e_mfd[d] = !(m_hit[d] || !di);
      e_mfu[d] = !(m_hit[d] || !ui);
      e_mmf[d] = !(m_mul[d] || !mi || (m_hit[d] && !di));
      e_ff[d]  = !(m_full[d] && !fi);
      e_cu[d]  = m_part[d] || cui;
      e_cd[d]  = m_part[d] || cdi;
      e_own[d] = m_hit[d] && di;
      e_nfa[d] = !fi && !m_full[d];
    end else if (m_st[d] == S_OFF) begin
      if (casc) begin
        e_mfu[d] = ui; e_mfd[d] = di; e_mmf[d] = mi; e_ff[d] = fi;
        e_cu[d] = cui; e_cd[d] = cdi;
      end else begin
        e_ff[d] = 0;
      end
    end
  endfunction

  function automatic void eval_model();
    logic up [3];
    logic cu [3];
    logic di, mi, fi, cdi;
    // up path first: lowest device has fixed inputs; only up-outputs matter here
    up[2] = 1; cu[2] = 0;
    for (int d = 2; d >= 0; d--) begin
      dev_out(d, 1, up[d], 1, 1, 0, cu[d], 0);
      if (d > 0) begin up[d-1] = e_mfu[d]; cu[d-1] = e_cu[d]; end
    end
    // down path with the true up inputs
    di = 1; mi = 1; fi = 0; cdi = 0;
    for (int d = 0; d < 3; d++) begin
      dev_out(d, 1, up[d], di, mi, fi, cu[d], cdi);
      di = e_mfd[d]; mi = e_mmf[d]; fi = e_ff[d]; cdi = e_cd[d];
    end
    dev_out(3, 0, 1, 1, 1, 0, 0, 0);
  endfunction

  // ---------------- checking ----------------
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic void chk(string tag, int d, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s dev%0d %s act=%0b exp=%0b t=%0t", tag, d, what, act, exp, $time);
    end
  endfunction

  function automatic string tg(int d, string on_tag);
    if (m_st[d] == S_OFF)  return (d == 3) ? "R8" : "R7";
    if (m_st[d] == S_WAKE) return "R1";
    return on_tag;
  endfunction

  function automatic void check_all();
    eval_model();
    for (int d = 0; d < ND; d++) begin
      chk(tg(d, "R3"), d, "mfd_out_n", w_mfd[d], e_mfd[d]);
      chk(tg(d, "R3"), d, "mfu_out_n", w_mfu[d], e_mfu[d]);
      chk(tg(d, "R3"), d, "smf_out_n", w_smf[d], e_mfd[d]);
      chk(tg(d, "R4"), d, "owns_o",    w_own[d], e_own[d]);
      chk(tg(d, "R5"), d, "mmf_out_n", w_mmf[d], e_mmf[d]);
      chk(tg(d, "R6"), d, "ff_out_n",  w_ff[d],  e_ff[d]);
      chk(tg(d, "R6"), d, "nfa_wr_o",  w_nfa[d], e_nfa[d]);
      chk(tg(d, "R9"), d, "cscu_out",  w_cu[d],  e_cu[d]);
      chk(tg(d, "R9"), d, "cscd_out",  w_cd[d],  e_cd[d]);
    end
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    check_all();
  endtask

  task automatic all_ops(logic [1:0] o);
    for (int d = 0; d < ND; d++) op[d] = o;
  endtask

  initial begin
    for (int d = 0; d < ND; d++) begin
      ce_n[d] = 0; op[d] = 2'd0; lm[d] = 0; lmm[d] = 0; lf[d] = 0;
    end
    rst = 1;
    repeat (3) tick();                        // R1 reset levels
    rst = 0;
    // R2: compare on a waking device is ignored
    op[0] = 2'd1; lm[0] = 1;
    tick();
    tick();
    chk("R2", 0, "owns_o after waking compare", w_own[0], 1'b0);
    all_ops(2'd0); lm[0] = 0;
    tick();                                   // all active now
    // R4/R5: middle and lowest both hit
    all_ops(2'd1); lm[1] = 1; lm[2] = 1;
    tick();
    tick();
    chk("R4", 1, "owns_o middle", w_own[1], 1'b1);
    chk("R4", 2, "owns_o lowest", w_own[2], 1'b0);
    chk("R5", 2, "mmf_out_n lowest", w_mmf[2], 1'b0);
    // R10: a non-compare keeps the hit
    all_ops(2'd3); lm[1] = 0; lm[2] = 0;
    tick();
    tick();
    chk("R10", 1, "owns_o held", w_own[1], 1'b1);
    // R6: highest fills up, grant moves down
    all_ops(2'd2); lf[0] = 1;
    tick();
    tick();
    chk("R6", 1, "nfa_wr_o middle", w_nfa[1], 1'b1);
    chk("R6", 0, "nfa_wr_o highest", w_nfa[0], 1'b0);
    lf[0] = 0;
    // R7/R8: deselect middle and lone device
    all_ops(2'd0); ce_n[1] = 1; ce_n[3] = 1;
    tick();
    tick();
    ce_n[1] = 0; ce_n[3] = 0;
    tick();
    tick();
    chk("R10", 0, "ff_out_n kept", w_ff[0], 1'b0);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      rst = ($urandom_range(0, 599) == 0);
      for (int d = 0; d < ND; d++) begin
        ce_n[d] = ($urandom_range(0, 11) == 0);
        op[d]   = 2'($urandom_range(0, 3));
        lm[d]   = ($urandom_range(0, 2) == 0);
        lmm[d]  = lm[d] && ($urandom_range(0, 3) == 0);
        lf[d]   = ($urandom_range(0, 1) == 0);
      end
      tick();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule